// File: doc/BRIEF.md
# Enable-Paced SPI Master

This block is a single-word SPI master that runs entirely from one system clock. It has no divided clocks. A free-running counter, reset together with the rest of the block, produces two single-cycle strobes. The bit strobe fires once every 2**DIV_W cycles and paces the framing state machine and the transmit shifter. The toggle strobe fires twice as often and flips a plain register that drives the serial clock pin. Because the serial clock is ordinary data, the rest of the chip never sees a second clock domain.

A client places a word on `tx_data_i` and pulses `start_i`. The block captures the word at once. It lowers chip select on the next bit strobe and shifts the word out MSB first in mode 0: MOSI changes on the falling serial-clock edges and MISO is sampled on the rising ones. After DATA_W bits, chip select rises. In the same cycle `done_o` pulses and the received word appears on `rx_data_o`. Setting QUARTER_PH moves the toggle decode so that the serial clock is shifted by a quarter of a bit period relative to the bit strobe.

Top module: `spi_ce_master`

## Requirements
In the rules below, posedges of `clk_i` are numbered from 1, starting with the first posedge after `rst_ni` is released. The values given are for DIV_W=4.
- R1: While `rst_ni` is low, `cs_no` is 1 and `sclk_o`, `mosi_o`, `done_o` and `rx_data_o` are all 0.
- R2: The divider runs from reset whether or not a frame is in progress. Chip select falls only at edges numbered 1 mod 16.
- R3: `sclk_o` changes only on the toggle strobe. With QUARTER_PH=0 it rises at edges numbered 9 mod 16 and falls at edges numbered 1 mod 16. With QUARTER_PH=1 it rises at edges numbered 5 mod 16 and falls at edges numbered 13 mod 16.
- R4: `sclk_o` is low whenever `cs_no` is high. Each frame holds exactly DATA_W rising `sclk_o` edges.
- R5: Suppose the block is idle and `start_i` is sampled high at edge s. Then `cs_no` falls at the first edge e >= s with e = 1 mod 16. It then stays low for exactly 16*DATA_W cycles.
- R6: `tx_data_i` is captured at the edge where the start request is sampled. The word leaves on `mosi_o` MSB first. `mosi_o` is 0 outside a frame and changes only at edges numbered 1 mod 16.
- R7: `miso_i` is sampled at each rising `sclk_o` edge. The first bit sampled becomes bit DATA_W-1 of `rx_data_o`.
- R8: `done_o` is high for exactly one cycle: the first cycle in which `cs_no` is high again. `rx_data_o` updates at that same edge and holds its value until the next frame completes.
- R9: A `start_i` pulse while a request is pending or a frame is active is ignored. It neither reloads the word nor causes an extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a transfer of tx_data_i |
| tx_data_i | input | DATA_W | Word to send, captured with the request |
| rx_data_o | output | DATA_W | Word received in the last completed frame |
| done_o | output | 1 | One-cycle pulse when a frame completes |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |

## Verification
The bench builds two copies side by side with DATA_W=8 and DIV_W=4: one with QUARTER_PH=0 and one with QUARTER_PH=1. Both run every one of the 256 transmit words against a slave model that returns a different word on each frame. The idle gap before each request varies through all 16 residues of the divider, so every alignment of request to bit strobe is exercised for both phase variants. Some frames receive extra requests while the first one is pending or already shifting.

// File: rtl/spi_ce_pkg.sv
package spi_ce_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } spi_st_e;

  // counter value (low DIV_W-1 bits) after which the toggle strobe is raised
  function automatic int tgl_decode(int div_w, bit quarter);
    return quarter ? (2 ** (div_w - 2)) - 1 : (2 ** (div_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/spi_ce_gen.sv
module spi_ce_gen
  import spi_ce_pkg::*;
#(
  parameter int DIV_W      = 4,
  parameter bit QUARTER_PH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bit_en_o,
  output logic tgl_en_o
);

  localparam logic [DIV_W-2:0] TGL_AT = (DIV_W-1)'(tgl_decode(DIV_W, QUARTER_PH));

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      bit_en_o <= 1'b0;
      tgl_en_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      bit_en_o <= (cnt_q == '1);
      tgl_en_o <= (cnt_q[DIV_W-2:0] == TGL_AT);
    end
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tgl_en_i,
  output logic sclk_o,
  output logic sample_o
);

  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sclk_q <= 1'b0;
    else if (!active_i)   sclk_q <= 1'b0;
    else if (tgl_en_i)    sclk_q <= ~sclk_q;
  end

  // rising edge of sclk is about to happen: capture miso now
  assign sample_o = active_i & tgl_en_i & ~sclk_q;
  assign sclk_o   = sclk_q;

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              capture_i,
  input  logic              active_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o
);

  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
    end else if (load_i) begin
      tx_sh_q <= data_i;
    end else if (shift_i) begin
      tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q <= '0;
    end else if (sample_i) begin
      rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_hold_q <= '0;
    else if (capture_i) rx_hold_q <= rx_sh_q;
  end

  assign mosi_o    = active_i & tx_sh_q[DATA_W-1];
  assign rx_data_o = rx_hold_q;

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_ce_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_en_i,
  output logic active_o,
  output logic cs_no,
  output logic done_o,
  output logic load_o,
  output logic shift_o,
  output logic capture_o
);

  localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(DATA_W - 1);

  spi_st_e         st_q;
  logic [BC_W-1:0] bit_q;
  logic            last_bit;

  assign active_o  = (st_q == ST_SHIFT);
  assign last_bit  = (bit_q == LAST_BIT);
  assign load_o    = (st_q == ST_IDLE) & start_i;
  assign shift_o   = active_o & bit_en_i & ~last_bit;
  assign capture_o = active_o & bit_en_i & last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      cs_no  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (bit_en_i) begin
              st_q  <= ST_SHIFT;
              bit_q <= '0;
              cs_no <= 1'b0;
            end else begin
              st_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (bit_en_i) begin
            st_q  <= ST_SHIFT;
            bit_q <= '0;
            cs_no <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (bit_en_i) begin
            if (last_bit) begin
              st_q   <= ST_IDLE;
              cs_no  <= 1'b1;
              done_o <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_ce_master.sv
module spi_ce_master #(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 4,
  parameter bit QUARTER_PH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no
);

  logic bit_en, tgl_en;
  logic active, load, shift, capture, sample;

  spi_ce_gen #(
    .DIV_W      (DIV_W),
    .QUARTER_PH (QUARTER_PH)
  ) u_ce (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_o (bit_en),
    .tgl_en_o (tgl_en)
  );

  spi_frame_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .bit_en_i  (bit_en),
    .active_o  (active),
    .cs_no     (cs_no),
    .done_o    (done_o),
    .load_o    (load),
    .shift_o   (shift),
    .capture_o (capture)
  );

  spi_sclk_gen u_sclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tgl_en_i (tgl_en),
    .sclk_o   (sclk_o),
    .sample_o (sample)
  );

  spi_shift_path #(
    .DATA_W (DATA_W)
  ) u_path (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .data_i    (tx_data_i),
    .shift_i   (shift),
    .sample_i  (sample),
    .capture_i (capture),
    .active_i  (active),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_data_o (rx_data_o)
  );

endmodule

// File: rtl/spi_ce_master_chk.sv
module spi_ce_master_chk #(
  parameter int DIV_W      = 4,
  parameter bit QUARTER_PH = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en,
  input logic tgl_en,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o,
  input logic done_o
);

  localparam int HALF_N = 2 ** (DIV_W - 1);
  localparam int TGL_N  = QUARTER_PH ? 2 ** (DIV_W - 2) : 0;
  localparam logic [DIV_W-2:0] TGL_AT = (DIV_W-1)'(TGL_N);
  localparam logic [DIV_W-2:0] TGL_PRE = (DIV_W-1)'((TGL_N + HALF_N - 1) % HALF_N);

  // independent reference phase
  logic [DIV_W-1:0] ref_c;
  logic             wrap_q, half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_c  <= '0;
      wrap_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      ref_c  <= ref_c + 1'b1;
      if (ref_c == '1) wrap_q <= 1'b1;
      if (ref_c[DIV_W-2:0] == TGL_PRE) half_q <= 1'b1;
    end
  end

  a_r2_bit_cadence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en == (wrap_q && ref_c == '0));

  a_r3_tgl_cadence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgl_en == (half_q && ref_c[DIV_W-2:0] == TGL_AT));

  a_r3_sclk_on_tgl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sclk_o) |-> $past(tgl_en));

  a_r4_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  a_r5_cs_fall_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(bit_en));

  a_r6_mosi_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> $past(bit_en));

  a_r8_done_with_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_no));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind spi_ce_master spi_ce_master_chk #(
  .DIV_W      (DIV_W),
  .QUARTER_PH (QUARTER_PH)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .bit_en (bit_en),
  .tgl_en (tgl_en),
  .cs_no  (cs_no),
  .sclk_o (sclk_o),
  .mosi_o (mosi_o),
  .done_o (done_o)
);

// File: tb/sim_spi_ce_master.sv
`timescale 1ns/1ps

module sim_spi_slave (
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] word,
  output logic       miso,
  output logic [7:0] got
);
  logic [7:0] sh = 8'h00;
  initial got = 8'h00;
  assign miso = sh[7];
  always @(negedge cs_n) sh = word;
  always @(posedge sclk) got = {got[6:0], mosi};
  always @(negedge sclk) if (!cs_n) sh = {sh[6:0], 1'b0};
endmodule

module sim_spi_ce_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [1:0] cs_n, sclk, mosi, miso, done;
  logic [7:0] rx   [2];
  logic [7:0] sw   [2];
  logic [7:0] got  [2];

  int checks = 0;
  int errors = 0;
  int ecnt   = 0;
  bit mon_on = 1'b0;
  int fall_e [2];
  int done_e [2];
  int rises  [2];
  int done_cnt [2];
  logic [1:0] p_cs, p_sclk, p_mosi, p_done;

  always #4 clk = ~clk;

  spi_ce_master #(.DATA_W(8), .DIV_W(4), .QUARTER_PH(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_data_i(tx_data),
    .rx_data_o(rx[0]), .done_o(done[0]), .sclk_o(sclk[0]), .mosi_o(mosi[0]),
    .miso_i(miso[0]), .cs_no(cs_n[0]));

  spi_ce_master #(.DATA_W(8), .DIV_W(4), .QUARTER_PH(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_data_i(tx_data),
    .rx_data_o(rx[1]), .done_o(done[1]), .sclk_o(sclk[1]), .mosi_o(mosi[1]),
    .miso_i(miso[1]), .cs_no(cs_n[1]));

  sim_spi_slave s0 (.cs_n(cs_n[0]), .sclk(sclk[0]), .mosi(mosi[0]), .word(sw[0]),
                    .miso(miso[0]), .got(got[0]));
  sim_spi_slave s1 (.cs_n(cs_n[1]), .sclk(sclk[1]), .mosi(mosi[1]), .word(sw[1]),
                    .miso(miso[1]), .got(got[1]));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d (edge %0d)", req, act, exp, ecnt);
    end
  endtask

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  // edge-phase monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < 2; i++) begin
        if (p_cs[i] && !cs_n[i]) begin
          chk("R2 cs fall phase", ecnt % 16, 1);
          fall_e[i] = ecnt;
          rises[i]  = 0;
        end
        if (!p_sclk[i] && sclk[i]) begin
          rises[i]++;
          chk("R3 sclk rise phase", ecnt % 16, i ? 5 : 9);
          chk("R4 sclk high only with cs low", int'(cs_n[i]), 0);
        end
        if (p_sclk[i] && !sclk[i])
          chk("R3 sclk fall phase", ecnt % 16, i ? 13 : 1);
        if (p_mosi[i] != mosi[i])
          chk("R6 mosi change phase", ecnt % 16, 1);
        if (done[i]) begin
          chk("R8 done with cs rise", int'({p_cs[i], cs_n[i]}), 1);
          chk("R8 done single cycle", int'(p_done[i]), 0);
          done_e[i] = ecnt;
          done_cnt[i]++;
        end
      end
    end
    p_cs = cs_n; p_sclk = sclk; p_mosi = mosi; p_done = done;
  end

  task automatic run_frame(input logic [7:0] tx, input int gap, input bit inject,
                           input bit chk_hold, input logic [7:0] prev0, input logic [7:0] prev1);
    int s, exp_fall, dc0, dc1, low_cnt;
    repeat (gap) @(negedge clk);
    if (chk_hold) begin
      chk("R8 rx held r0", int'(rx[0]), int'(prev0));
      chk("R8 rx held r1", int'(rx[1]), int'(prev1));
    end
    sw[0] = 8'(tx * 37 + 11);
    sw[1] = ~tx ^ 8'h3C;
    tx_data = tx;
    start = 1'b1;
    s = ecnt + 1;
    dc0 = done_cnt[0];
    dc1 = done_cnt[1];
    @(negedge clk);
    tx_data = inject ? 8'hA5 : ~tx;
    start = inject;
    @(negedge clk);
    start = 1'b0;
    tx_data = ~tx;
    if (inject) begin
      repeat (60) @(negedge clk);
      tx_data = 8'h5A;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt[0] == dc0 || done_cnt[1] == dc1) @(posedge clk);
    @(negedge clk);
    exp_fall = s + ((17 - (s % 16)) % 16);
    chk("R5 accept edge u0", fall_e[0], exp_fall);
    chk("R5 accept edge u1", fall_e[1], exp_fall);
    chk("R5 frame length u0", done_e[0] - fall_e[0], 128);
    chk("R5 frame length u1", done_e[1] - fall_e[1], 128);
    chk("R4 rises u0", rises[0], 8);
    chk("R4 rises u1", rises[1], 8);
    chk("R6 mosi word u0", int'(got[0]), int'(tx));
    chk("R6 mosi word u1", int'(got[1]), int'(tx));
    chk("R7 rx word u0", int'(rx[0]), int'(sw[0]));
    chk("R7 rx word u1", int'(rx[1]), int'(sw[1]));
    if (inject) begin
      low_cnt = 0;
      repeat (40) begin
        @(negedge clk);
        if (cs_n != 2'b11) low_cnt++;
      end
      chk("R9 no extra frame", low_cnt, 0);
      chk("R9 no extra done", done_cnt[0] - dc0, 1);
    end
  endtask

  initial begin
    int idle_low;
    logic [7:0] prev0, prev1;
    sw[0] = 8'h00;
    sw[1] = 8'h00;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk("R1 cs reset", int'(cs_n[i]), 1);
      chk("R1 sclk reset", int'(sclk[i]), 0);
      chk("R1 mosi reset", int'(mosi[i]), 0);
      chk("R1 done reset", int'(done[i]), 0);
      chk("R1 rx reset", int'(rx[i]), 0);
    end
    p_cs = 2'b11; p_sclk = 2'b00; p_mosi = 2'b00; p_done = 2'b00;
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle_low = 0;
    repeat (48) begin
      @(negedge clk);
      if (cs_n != 2'b11 || sclk != 2'b00) idle_low++;
    end
    chk("R5 no frame without request", idle_low, 0);
    prev0 = 8'h00;
    prev1 = 8'h00;
    for (int k = 0; k < 256; k++) begin
      run_frame(8'(k), k % 16, (k % 32) == 5, k > 0, prev0, prev1);
      prev0 = rx[0];
      prev1 = rx[1];
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog act=timeout exp=all frames complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule